// File: doc/BRIEF.md
# Guarded Accumulator ALU Stage

This block is the arithmetic and logic stage of a DSP data path. It holds two 36-bit accumulators: 32 data bits with 4 guard bits above them. On each accepted operation it combines one accumulator, the source, with a 32-bit operand called y. It then writes the result into an accumulator chosen separately, the destination, and updates a 4-bit condition flag register. Two compare-style opcodes compute a result and update only the flags. They leave both accumulators untouched.

Operations arrive as a single-beat stream qualified by `op_valid_i`. The stage has no back-pressure: it accepts one operation on every rising clock edge where `op_valid_i` is high, so an upstream producer may present a new operation every cycle. The results show up on the accumulator and flag outputs right after the accepting edge. Multiplication, shifting, store saturation and instruction decode belong to other stages.

Top module: `acc_alu`

## Requirements
- R1: An active-low reset clears both accumulators and all four flags.
- R2: Opcode 3'd0 (add) writes source plus y, with y sign-extended from bit 31 to 36 bits, into the destination. The result is taken modulo 2^36.
- R3: Opcode 3'd1 (subtract) writes source minus sign-extended y into the destination. y is the subtrahend.
- R4: Opcodes 3'd2, 3'd3 and 3'd4 write source AND, OR and XOR y into the destination. For these, y is zero-extended to 36 bits.
- R5: Source select and destination select are independent, with 0 meaning the first accumulator and 1 the second. An accumulator that is not the destination keeps its value.
- R6: The flag output packs negative in bit 3, zero in bit 2, overflow in bit 1 and carry in bit 0. Negative equals result bit 35. Zero is set when all 36 result bits are zero.
- R7: Overflow is set when result bits 35 down to 31 are not all equal, meaning the value does not fit in 32 signed bits.
- R8: For add, carry is the carry out of bit 35. For subtract and compare, carry is the carry out of source + ~y + 1 over 36 bits, so 1 means no borrow. Logical opcodes clear carry.
- R9: Opcode 3'd5 (compare) sets the flags exactly as a subtract would and writes no accumulator.
- R10: Opcode 3'd6 (test) sets the flags exactly as an AND would and writes no accumulator.
- R11: Nothing changes on an edge where `op_valid_i` is low. Nothing changes on an edge that carries the reserved opcode 3'd7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation present; accepted on every edge where high |
| op_code_i | input | 3 | Operation code (see requirements) |
| src_sel_i | input | 1 | Source accumulator select |
| dst_sel_i | input | 1 | Destination accumulator select |
| y_i | input | 32 | y operand |
| acc0_o | output | 36 | First accumulator |
| acc1_o | output | 36 | Second accumulator |
| flags_o | output | 4 | {negative, zero, overflow, carry} |

## Verification
Every piece of state in this stage drives a port directly. A wrong accumulator or flag value therefore shows up on the first clock edge after the operation that caused it, with no latency to hide it. A wrong result can also sit in an accumulator and reappear at the ports once a later operation uses it as source. Flag errors from compare and test are visible only on the flag outputs. Writes to the wrong destination show up as a change on the accumulator that should have held still.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CMP = 3'd5,
    OP_TST = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } alu_flags_t;

  function automatic logic op_writes_acc(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR);
  endfunction

  function automatic logic op_sets_flags(alu_op_e op);
    return op_writes_acc(op) || (op == OP_CMP) || (op == OP_TST);
  endfunction

endpackage

// File: rtl/acc_alu_operand.sv
module acc_alu_operand
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 4,
  parameter int NUM_ACC = 2,
  localparam int ACC_W  = DATA_W + GUARD_W,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic [ACC_W-1:0]  acc_i [NUM_ACC],
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [ACC_W-1:0]  src_o,
  output logic [ACC_W-1:0]  y_sext_o,
  output logic [ACC_W-1:0]  y_zext_o
);

  always_comb begin
    src_o = '0;
    for (int k = 0; k < NUM_ACC; k++) begin
      if (src_sel_i == SEL_W'(k)) src_o = acc_i[k];
    end
  end

  assign y_sext_o = {{GUARD_W{y_i[DATA_W-1]}}, y_i};
  assign y_zext_o = {{GUARD_W{1'b0}}, y_i};

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 4,
  localparam int ACC_W  = DATA_W + GUARD_W
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] y_sext_i,
  input  logic [ACC_W-1:0] y_zext_i,
  input  alu_op_e          op_i,
  output logic [ACC_W-1:0] res_o,
  output alu_flags_t       flags_o,
  output logic             wr_o,
  output logic             fl_o
);

  logic [ACC_W:0]   sum_w;
  logic [ACC_W:0]   dif_w;
  logic             carry_w;
  logic [GUARD_W:0] top_bits;

  assign sum_w = {1'b0, a_i} + {1'b0, y_sext_i};
  assign dif_w = {1'b0, a_i} + {1'b0, ~y_sext_i} + {{ACC_W{1'b0}}, 1'b1};

  always_comb begin
    res_o   = a_i;
    carry_w = 1'b0;
    unique case (op_i)
      OP_ADD:         begin res_o = sum_w[ACC_W-1:0]; carry_w = sum_w[ACC_W]; end
      OP_SUB, OP_CMP: begin res_o = dif_w[ACC_W-1:0]; carry_w = dif_w[ACC_W]; end
      OP_AND, OP_TST: res_o = a_i & y_zext_i;
      OP_OR:          res_o = a_i | y_zext_i;
      OP_XOR:         res_o = a_i ^ y_zext_i;
      default:        res_o = a_i;
    endcase
  end

  assign top_bits      = res_o[ACC_W-1:DATA_W-1];
  assign flags_o.neg   = res_o[ACC_W-1];
  assign flags_o.zero  = (res_o == '0);
  assign flags_o.ovf   = (|top_bits) && !(&top_bits);
  assign flags_o.carry = carry_w;

  assign wr_o = op_writes_acc(op_i);
  assign fl_o = op_sets_flags(op_i);

endmodule

// File: rtl/acc_alu_regs.sv
module acc_alu_regs
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 4,
  parameter int NUM_ACC = 2,
  localparam int ACC_W  = DATA_W + GUARD_W,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             wr_i,
  input  logic             fl_i,
  input  logic [SEL_W-1:0] dst_i,
  input  logic [ACC_W-1:0] res_i,
  input  alu_flags_t       flags_i,
  output logic [ACC_W-1:0] acc_o [NUM_ACC],
  output alu_flags_t       flags_o
);

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_o[i] <= '0;
      end else if (valid_i && wr_i && (dst_i == SEL_W'(i))) begin
        acc_o[i] <= res_i;
      end
    end

    // R5: only the selected destination may change
    a_r5_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && wr_i && (dst_i != SEL_W'(i))) |=> $stable(acc_o[i]));

    // R9 / R10: flag-only opcodes never touch an accumulator
    a_r9_flag_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && fl_i && !wr_i) |=> $stable(acc_o[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
    end else if (valid_i && fl_i) begin
      flags_o <= flags_i;
    end
  end

  // R11: idle edges leave flags alone
  a_r11_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o));

  // R6: zero flag agrees with the accumulator just written
  a_r6_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wr_i) |=> (flags_o.zero == (acc_o[$past(dst_i)] == '0)));

  // R6: negative flag agrees with the sign of the accumulator just written
  a_r6_neg_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wr_i) |=> (flags_o.neg == acc_o[$past(dst_i)][ACC_W-1]));

  // R7: overflow agrees with the guard bits of the accumulator just written
  a_r7_ovf_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wr_i) |=> (flags_o.ovf ==
      ((|acc_o[$past(dst_i)][ACC_W-1:DATA_W-1]) && !(&acc_o[$past(dst_i)][ACC_W-1:DATA_W-1]))));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 4,
  localparam int ACC_W  = DATA_W + GUARD_W,
  localparam int NUM_ACC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [2:0]        op_code_i,
  input  logic              src_sel_i,
  input  logic              dst_sel_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [ACC_W-1:0]  acc0_o,
  output logic [ACC_W-1:0]  acc1_o,
  output logic [3:0]        flags_o
);

  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [ACC_W-1:0] src_w, ys_w, yz_w, res_w;
  alu_flags_t       nxt_flags, flags_q;
  logic             wr_w, fl_w;
  alu_op_e          op_w;

  assign op_w = alu_op_e'(op_code_i);

  acc_alu_operand #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .NUM_ACC(NUM_ACC)) u_operand (
    .acc_i     (acc_q),
    .src_sel_i (src_sel_i),
    .y_i       (y_i),
    .src_o     (src_w),
    .y_sext_o  (ys_w),
    .y_zext_o  (yz_w)
  );

  acc_alu_core #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_core (
    .a_i      (src_w),
    .y_sext_i (ys_w),
    .y_zext_i (yz_w),
    .op_i     (op_w),
    .res_o    (res_w),
    .flags_o  (nxt_flags),
    .wr_o     (wr_w),
    .fl_o     (fl_w)
  );

  acc_alu_regs #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .NUM_ACC(NUM_ACC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (op_valid_i),
    .wr_i    (wr_w),
    .fl_i    (fl_w),
    .dst_i   (dst_sel_i),
    .res_i   (res_w),
    .flags_i (nxt_flags),
    .acc_o   (acc_q),
    .flags_o (flags_q)
  );

  assign acc0_o  = acc_q[0];
  assign acc1_o  = acc_q[1];
  assign flags_o = flags_q;

  // R11: the reserved opcode changes nothing
  a_r11_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_code_i == 3'd7) |=> ($stable(acc0_o) && $stable(acc1_o) && $stable(flags_o)));

  // R8: logical results never carry
  a_r8_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && (op_code_i inside {3'd2, 3'd3, 3'd4, 3'd6})) |=> !flags_o[0]);

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_code_i = 3'd0;
  logic        src_sel_i = 1'b0;
  logic        dst_sel_i = 1'b0;
  logic [31:0] y_i = '0;
  logic [35:0] acc0_o, acc1_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [35:0] e0;
    logic [35:0] e1;
    logic [3:0]  ef;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [35:0] m_acc [2];
  logic [3:0]  m_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .src_sel_i(src_sel_i), .dst_sel_i(dst_sel_i), .y_i(y_i),
    .acc0_o(acc0_o), .acc1_o(acc1_o), .flags_o(flags_o)
  );

  task automatic compare(input string tag, input logic [35:0] e0, input logic [35:0] e1,
                         input logic [3:0] ef);
    checks++;
    if (acc0_o !== e0 || acc1_o !== e1 || flags_o !== ef) begin
      errors++;
      $display("FAIL %s acc0=%h/%h acc1=%h/%h flags=%b/%b (actual/expected)",
               tag, acc0_o, e0, acc1_o, e1, flags_o, ef);
    end
  endtask

  // Driver: present one operation, update the reference, queue the expectation
  task automatic drive(input logic [2:0] op, input logic s, input logic d,
                       input logic [31:0] y, input logic v, input string tag);
    logic [35:0] a, ys, yz, r;
    logic [36:0] wide;
    logic c, wr, fl;
    exp_t e;
    @(negedge clk);
    op_valid_i = v; op_code_i = op; src_sel_i = s; dst_sel_i = d; y_i = y;
    a  = m_acc[s];
    ys = {{4{y[31]}}, y};
    yz = {4'h0, y};
    r = a; c = 1'b0; wr = 1'b0; fl = 1'b0;
    case (op)
      3'd0: begin wide = {1'b0, a} + {1'b0, ys}; r = wide[35:0]; c = wide[36]; wr = 1; fl = 1; end
      3'd1, 3'd5: begin
        wide = {1'b0, a} + {1'b0, ~ys} + 37'd1; r = wide[35:0]; c = wide[36];
        wr = (op == 3'd1); fl = 1;
      end
      3'd2, 3'd6: begin r = a & yz; wr = (op == 3'd2); fl = 1; end
      3'd3: begin r = a | yz; wr = 1; fl = 1; end
      3'd4: begin r = a ^ yz; wr = 1; fl = 1; end
      default: ;
    endcase
    if (v && fl) m_fl = {r[35], r == 36'd0, (r[35:31] != 5'b00000) && (r[35:31] != 5'b11111), c};
    if (v && wr) m_acc[d] = r;
    e.e0 = m_acc[0]; e.e1 = m_acc[1]; e.ef = m_fl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each accepting edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare(e.tag, e.e0, e.e1, e.ef);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_acc[0] = '0; m_acc[1] = '0; m_fl = '0;
    repeat (3) @(negedge clk);
    compare("R1 reset", 36'd0, 36'd0, 4'd0);
    rst_n = 1'b1;

    drive(3'd0, 0, 0, 32'h1234_5678, 1, "R2 add positive");
    drive(3'd0, 0, 1, 32'h8000_0000, 1, "R2 R6 add sign-extended negative");
    drive(3'd0, 1, 1, 32'h8000_0000, 1, "R8 R7 add carry out and guard overflow");
    drive(3'd0, 0, 0, 32'h7FFF_FFFF, 1, "R7 add past 32 bits");
    drive(3'd1, 0, 1, 32'h0000_0001, 1, "R3 R5 subtract into other accumulator");
    drive(3'd1, 1, 0, 32'hFFFF_FFFF, 1, "R3 subtract minus one");
    drive(3'd2, 0, 0, 32'hF0F0_F0F0, 1, "R4 and zero-extended");
    drive(3'd3, 1, 1, 32'h0000_FFFF, 1, "R4 or");
    drive(3'd4, 0, 1, 32'hFFFF_FFFF, 1, "R4 R5 xor");
    drive(3'd2, 0, 0, 32'h0000_0000, 1, "R6 zero result");
    drive(3'd0, 0, 0, 32'h1234_5678, 1, "R2 reload");
    drive(3'd5, 0, 1, 32'h1234_5678, 1, "R9 compare equal no write");
    drive(3'd5, 0, 0, 32'h1234_5679, 1, "R9 R8 compare borrow");
    drive(3'd6, 1, 0, 32'h0000_0000, 1, "R10 test zero no write");
    drive(3'd6, 0, 1, 32'h0000_0010, 1, "R10 test nonzero");
    drive(3'd7, 0, 0, 32'hDEAD_BEEF, 1, "R11 reserved opcode");
    drive(3'd0, 0, 0, 32'h0000_0005, 0, "R11 valid low");
    drive(3'd1, 1, 1, 32'h0000_0003, 1, "R5 same source and destination");
    drive(3'd1, 0, 0, 32'h1234_5678, 1, "R3 R6 subtract to zero");
    drive(3'd0, 0, 0, 32'h0000_0001, 0, "R11 idle");
    @(negedge clk);
    op_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending=%0d expected=0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule